// File: doc/BRIEF.md
# Paired Word-Mover Channels for a Serial Port

This block sits beside a serial peripheral. It moves data words between that peripheral's data register and system memory, so software does not have to touch every word. It has two independent channels. The inbound channel copies words from the peripheral into a memory buffer. The outbound channel copies words from a memory buffer into the peripheral. Software loads each channel with a start address and a word count. Each channel then runs by itself, driven only by the peripheral's "data waiting" and "room available" flags.

Every transfer lowers the channel's count by one and moves its address forward by the transfer size. While a channel's count is zero, its done flag stays high and the channel stays idle. A per-channel enable routes that done flag to a shared interrupt line. The two channels share one memory port. A request is held, with a steady address, until memory grants it.

Top module: `xfer_chan_pair`

## Requirements
- R1: After reset, both addresses and both counts are zero, both done flags are high, the interrupt is low, and `spi_rd`, `spi_wr` and `mem_req` are low.
- R2: When `spi_rx_full` is high, the inbound count is nonzero and the channel is idle, the channel does two things. First it raises `spi_rd` for exactly one cycle and captures `spi_rx_data`. Then it writes that word to memory at the inbound address, with `mem_we` high. In byte mode the upper byte of the written word is zero.
- R3: When `spi_tx_empty` is high, the outbound count is nonzero and the channel is idle, the channel does two things. First it reads memory at the outbound address, with `mem_we` low. Then it presents the word on `spi_tx_data` with `spi_wr` high for exactly one cycle. In byte mode only bits 7:0 of the memory word are passed, zero-extended.
- R4: Each granted memory access lowers that channel's count by 1. On the same clock edge it adds the step to that channel's address: 1 in byte mode, 2 in halfword mode.
- R5: A channel's done flag is high exactly when its count is zero. After the final grant, the flag is high in the cycle that follows.
- R6: While a channel's count is zero, a raised peripheral flag causes no peripheral strobe and no memory request.
- R7: Each assertion of a peripheral flag produces at most one transfer. The flag must be seen low before that channel starts again.
- R8: The register map is selected by `cfg_addr`: 0 is the inbound address, 1 the inbound count, 2 the outbound address and 3 the outbound count. Writing a nonzero count lowers the done flag from the next cycle. Writing an address leaves the done flag unchanged.
- R9: Address 4 is the control register. Bit 0 enables the inbound interrupt, bit 1 enables the outbound interrupt, and bit 2 selects halfword mode (0 selects byte mode). `irq` is high when an enabled channel's done flag is high.
- R10: A memory request stays asserted, with a stable address and direction, until it is granted. Both channels can run at the same time through the shared port, and each keeps its own data intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | ADDR_W | Register write value |
| spi_rx_full | input | 1 | Peripheral holds an unread word |
| spi_rx_data | input | DATA_W | Peripheral receive word |
| spi_rd | output | 1 | Read strobe that empties the peripheral receive register |
| spi_tx_empty | input | 1 | Peripheral can accept a word |
| spi_wr | output | 1 | Write strobe into the peripheral transmit register |
| spi_tx_data | output | DATA_W | Word for the peripheral |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_half | output | 1 | Transfer size, 1 = halfword |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory grant, completes the request on this edge |
| mem_rdata | input | DATA_W | Memory read data, valid with the grant |
| rx_ptr | output | ADDR_W | Inbound address |
| rx_cnt | output | CNT_W | Inbound count |
| rx_end | output | 1 | Inbound done flag |
| tx_ptr | output | ADDR_W | Outbound address |
| tx_cnt | output | CNT_W | Outbound count |
| tx_end | output | 1 | Outbound done flag |
| irq | output | 1 | Combined interrupt |

## Verification
An inbound flag first seen at a rising edge brings `spi_rd` one cycle later. The memory request follows one cycle after that. The count, address and done flag change on the grant edge. An outbound word reaches `spi_wr` one cycle after its grant. A register write is visible one cycle after the write edge. The bench drives every input and samples every output on the falling edge. The cycle-exact checks step through those edges one at a time. The sweeps instead wait, with a bound, for the done flag, and then compare the memory, the addresses and the logged peripheral words against values computed from the run's pattern.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RD   = 2'd1,
    CH_MEM  = 2'd2,
    CH_PUT  = 2'd3
  } ch_state_e;

  localparam int          NUM_CH   = 2;
  localparam int          SEL_W    = 3;
  localparam logic [2:0]  REG_CTRL = 3'd4;
  localparam int          CTRL_HALF_BIT = 2;
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_i,
  input  logic              ptr_we_i,
  input  logic              cnt_we_i,
  input  logic [ADDR_W-1:0] wval_i,
  input  logic              half_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              req_o,
  output logic              strobe_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              end_o
);
  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);

  ch_state_e         state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              armed_q, armed_d;
  logic              ptr_en, cnt_en, buf_en;
  logic              start, done;
  logic [ADDR_W-1:0] step;
  logic [DATA_W-1:0] shaped;

  assign step   = half_i ? STEP_HALF : STEP_BYTE;
  assign shaped = half_i ? din_i : {{(DATA_W-BYTE_W){1'b0}}, din_i[BYTE_W-1:0]};
  assign start  = (state_q == CH_IDLE) && flag_i && armed_q && (cnt_q != '0);
  assign done   = (state_q == CH_MEM) && gnt_i;

  // next-state logic
  always_comb begin
    state_d = state_q;
    buf_d   = buf_q;
    buf_en  = 1'b0;
    armed_d = armed_q;
    if (!flag_i) armed_d = 1'b1;
    case (state_q)
      CH_IDLE: begin
        if (start) begin
          state_d = IS_TX ? CH_MEM : CH_RD;
          armed_d = 1'b0;
        end
      end
      CH_RD: begin
        buf_d   = shaped;
        buf_en  = 1'b1;
        state_d = CH_MEM;
      end
      CH_MEM: begin
        if (gnt_i) begin
          if (IS_TX) begin
            buf_d   = shaped;
            buf_en  = 1'b1;
            state_d = CH_PUT;
          end else begin
            state_d = CH_IDLE;
          end
        end
      end
      CH_PUT:  state_d = CH_IDLE;
      default: state_d = CH_IDLE;
    endcase
  end

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (ptr_we_i) begin
      ptr_d  = wval_i;
      ptr_en = 1'b1;
    end else if (done) begin
      ptr_d  = ptr_q + step;
      ptr_en = 1'b1;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cnt_we_i) begin
      cnt_d  = wval_i[CNT_W-1:0];
      cnt_en = 1'b1;
    end else if (done) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  assign req_o    = (state_q == CH_MEM);
  assign strobe_o = IS_TX ? (state_q == CH_PUT) : (state_q == CH_RD);
  assign dout_o   = buf_q;
  assign ptr_o    = ptr_q;
  assign cnt_o    = cnt_q;
  assign end_o    = (cnt_q == '0);
endmodule

// File: rtl/xfer_arb.sv
module xfer_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic       gnt_i,
  output logic       sel_o
);
  logic owner_q, owner_d;
  logic hold_q, hold_d;

  always_comb begin
    if (hold_q && req_i[owner_q]) owner_d = owner_q;
    else if (req_i[0])            owner_d = 1'b0;
    else                          owner_d = 1'b1;
    hold_d = req_i[owner_d] && !gnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      owner_q <= owner_d;
      hold_q  <= hold_d;
    end
  end

  assign sel_o = owner_d;
endmodule

// File: rtl/xfer_chan_pair.sv
module xfer_chan_pair
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              spi_rx_full,
  input  logic [DATA_W-1:0] spi_rx_data,
  output logic              spi_rd,
  input  logic              spi_tx_empty,
  output logic              spi_wr,
  output logic [DATA_W-1:0] spi_tx_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] rx_ptr,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic              rx_end,
  output logic [ADDR_W-1:0] tx_ptr,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic              tx_end,
  output logic              irq
);
  logic                     rst_i_n;
  logic [NUM_CH-1:0]        flag_v, ptr_we_v, cnt_we_v, gnt_v, req_v, strobe_v, end_v;
  logic [DATA_W-1:0]        din_v  [NUM_CH];
  logic [DATA_W-1:0]        dout_v [NUM_CH];
  logic [ADDR_W-1:0]        ptr_v  [NUM_CH];
  logic [CNT_W-1:0]         cnt_v  [NUM_CH];
  logic [NUM_CH-1:0]        ie_q, ie_d;
  logic                     half_q, half_d;
  logic                     ctrl_en;
  logic                     sel;

  xfer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // control register
  assign ctrl_en = cfg_we && (cfg_addr == REG_CTRL);
  assign ie_d    = cfg_wdata[NUM_CH-1:0];
  assign half_d  = cfg_wdata[CTRL_HALF_BIT];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ie_q   <= '0;
      half_q <= 1'b0;
    end else if (ctrl_en) begin
      ie_q   <= ie_d;
      half_q <= half_d;
    end
  end

  assign flag_v[0] = spi_rx_full;
  assign flag_v[1] = spi_tx_empty;
  assign din_v[0]  = spi_rx_data;
  assign din_v[1]  = mem_rdata;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ptr_we_v[i] = cfg_we && (cfg_addr == SEL_W'(2*i));
    assign cnt_we_v[i] = cfg_we && (cfg_addr == SEL_W'(2*i+1));
    assign gnt_v[i]    = mem_gnt && (sel == i[0]);

    xfer_chan #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .IS_TX  (i == 1)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .flag_i   (flag_v[i]),
      .ptr_we_i (ptr_we_v[i]),
      .cnt_we_i (cnt_we_v[i]),
      .wval_i   (cfg_wdata),
      .half_i   (half_q),
      .gnt_i    (gnt_v[i]),
      .din_i    (din_v[i]),
      .req_o    (req_v[i]),
      .strobe_o (strobe_v[i]),
      .dout_o   (dout_v[i]),
      .ptr_o    (ptr_v[i]),
      .cnt_o    (cnt_v[i]),
      .end_o    (end_v[i])
    );
  end

  xfer_arb u_arb (
    .clk   (clk),
    .rst_n (rst_i_n),
    .req_i (req_v),
    .gnt_i (mem_gnt),
    .sel_o (sel)
  );

  assign mem_req     = req_v[sel];
  assign mem_we      = !sel;
  assign mem_half    = half_q;
  assign mem_addr    = ptr_v[sel];
  assign mem_wdata   = dout_v[0];
  assign spi_tx_data = dout_v[1];
  assign spi_rd      = strobe_v[0];
  assign spi_wr      = strobe_v[1];
  assign rx_ptr      = ptr_v[0];
  assign rx_cnt      = cnt_v[0];
  assign rx_end      = end_v[0];
  assign tx_ptr      = ptr_v[1];
  assign tx_cnt      = cnt_v[1];
  assign tx_end      = end_v[1];
  assign irq         = |(ie_q & end_v);
endmodule

// File: rtl/xfer_chan_pair_chk.sv
module xfer_chan_pair_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              spi_rd,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              rx_end,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic              tx_end,
  input logic              irq
);
  // R7: a receive strobe never lasts two cycles
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    spi_rd |=> !spi_rd);

  // R6: no receive strobe while the inbound count is zero
  a_r6_idle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> !spi_rd);

  // R10: an ungranted request holds address and direction
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: interrupt only from a finished channel
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_end || tx_end));

  // R4: without a register write, counts hold or step down by one
  a_r4_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((rx_cnt == $past(rx_cnt)) || (rx_cnt == $past(rx_cnt) - CNT_W'(1))));

  a_r4_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((tx_cnt == $past(tx_cnt)) || (tx_cnt == $past(tx_cnt) - CNT_W'(1))));

  // R5: the final grant raises the done flag one cycle later
  a_r5_rx_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && mem_we && rx_cnt == CNT_W'(1) && !cfg_we) |=> rx_end);

  a_r5_tx_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_we && tx_cnt == CNT_W'(1) && !cfg_we) |=> tx_end);
endmodule

bind xfer_chan_pair xfer_chan_pair_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .spi_rd   (spi_rd),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .rx_cnt   (rx_cnt),
  .rx_end   (rx_end),
  .tx_cnt   (tx_cnt),
  .tx_end   (tx_end),
  .irq      (irq)
);

// File: tb/xfer_chan_pair_tb.sv
module xfer_chan_pair_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        spi_rx_full;
  logic [15:0] spi_rx_data;
  logic        spi_rd;
  logic        spi_tx_empty;
  logic        spi_wr;
  logic [15:0] spi_tx_data;
  logic        mem_req, mem_we, mem_half, mem_gnt;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] rx_ptr, tx_ptr;
  logic [7:0]  rx_cnt, tx_cnt;
  logic        rx_end, tx_end, irq;

  xfer_chan_pair u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .spi_rx_full(spi_rx_full), .spi_rx_data(spi_rx_data), .spi_rd(spi_rd),
    .spi_tx_empty(spi_tx_empty), .spi_wr(spi_wr), .spi_tx_data(spi_tx_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .rx_ptr(rx_ptr), .rx_cnt(rx_cnt), .rx_end(rx_end),
    .tx_ptr(tx_ptr), .tx_cnt(tx_cnt), .tx_end(tx_end), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // stimulus requests, written only by the main initial block
  int rx_target = 0;
  int tx_target = 0;
  bit rx_hold = 0;
  int lat = 0;

  // model state, written only by the model block
  int rx_sent = 0, tx_raised = 0, tx_got = 0;
  int rd_total = 0, wr_total = 0, mreq_total = 0;
  int lat_cnt = 0;
  bit rx_stale = 0;
  logic [15:0] wmem [256];
  logic [15:0] tx_log [256];

  function automatic logic [15:0] rxpat(int k);
    return 16'(32'hA5C3 ^ (k * 37));
  endfunction

  function automatic logic [15:0] txpat(logic [15:0] a);
    return 16'((a * 29) ^ 32'h5A3C);
  endfunction

  function automatic logic [15:0] shape(logic [15:0] v, int hw);
    return (hw != 0) ? v : {8'h00, v[7:0]};
  endfunction

  initial begin
    spi_rx_full = 1'b0; spi_tx_empty = 1'b0; spi_rx_data = '0;
    mem_gnt = 1'b0; mem_rdata = '0;
  end

  // peripheral and memory model, acting on the falling edge
  always @(negedge clk) begin
    if (mem_req) begin
      mreq_total++;
      if (lat_cnt >= lat) begin
        mem_gnt = 1'b1;
        mem_rdata = txpat(mem_addr);
        if (mem_we) wmem[mem_addr[7:0]] = mem_wdata;
        lat_cnt = 0;
      end else begin
        mem_gnt = 1'b0;
        lat_cnt++;
      end
    end else begin
      mem_gnt = 1'b0;
      lat_cnt = 0;
    end
    if (spi_rd) begin
      rd_total++;
      rx_sent++;
      if (rx_hold) rx_stale = 1;
      else spi_rx_full = 1'b0;
    end else if (rx_stale && !rx_hold) begin
      spi_rx_full = 1'b0;
      rx_stale = 0;
    end else if (!spi_rx_full && rx_sent < rx_target) begin
      spi_rx_full = 1'b1;
      spi_rx_data = rxpat(rx_sent);
    end
    if (spi_wr) begin
      wr_total++;
      tx_log[tx_got[7:0]] = spi_tx_data;
      tx_got++;
      spi_tx_empty = 1'b0;
    end else if (!spi_tx_empty && tx_raised < tx_target) begin
      spi_tx_empty = 1'b1;
      tx_raised++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rx_done();
    for (int c = 0; c < 400; c++) begin
      if (rx_end) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_tx_done(input int wr_goal);
    for (int c = 0; c < 400; c++) begin
      if (tx_end && wr_total >= wr_goal) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic run_rx(input int n, input int hw, input int l);
    int k0;
    bit ok;
    logic [15:0] base, step;
    base = 16'h0040; step = (hw != 0) ? 16'd2 : 16'd1;
    lat = l;
    cfg_write(3'd4, 16'(hw * 4 + 1));
    cfg_write(3'd0, base);
    k0 = rx_sent;
    rx_target = rx_target + n;
    cfg_write(3'd1, 16'(n));
    wait_rx_done();
    ok = 1;
    for (int k = 0; k < n; k++)
      if (wmem[8'(base + 16'(k) * step)] !== shape(rxpat(k0 + k), hw)) ok = 0;
    chk(ok, "R2 inbound words in memory", n, hw);
    chk(rx_ptr == base + 16'(n) * step, "R4 inbound address advance", rx_ptr, base + 16'(n) * step);
    chk(rx_cnt == 0 && rx_end, "R5 inbound count zero and done", rx_cnt, 0);
    chk(irq == 1'b1, "R9 inbound irq enabled", irq, 1);
  endtask

  task automatic run_tx(input int n, input int hw, input int l);
    int g0, w0;
    bit ok;
    logic [15:0] base, step;
    base = 16'h0080; step = (hw != 0) ? 16'd2 : 16'd1;
    lat = l;
    cfg_write(3'd4, 16'(hw * 4 + 2));
    cfg_write(3'd2, base);
    g0 = tx_got; w0 = wr_total;
    tx_target = tx_target + n;
    cfg_write(3'd3, 16'(n));
    wait_tx_done(w0 + n);
    ok = (wr_total == w0 + n);
    for (int k = 0; k < n; k++)
      if (tx_log[8'(g0 + k)] !== shape(txpat(base + 16'(k) * step), hw)) ok = 0;
    chk(ok, "R3 outbound words to peripheral", wr_total - w0, n);
    chk(tx_ptr == base + 16'(n) * step, "R4 outbound address advance", tx_ptr, base + 16'(n) * step);
    chk(tx_cnt == 0 && tx_end, "R5 outbound count zero and done", tx_cnt, 0);
    chk(irq == 1'b1, "R9 outbound irq enabled", irq, 1);
  endtask

  initial begin
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rx_ptr == 0 && tx_ptr == 0, "R1 pointers zero", rx_ptr | tx_ptr, 0);
    chk(rx_cnt == 0 && tx_cnt == 0, "R1 counts zero", rx_cnt | tx_cnt, 0);
    chk(rx_end && tx_end && !irq, "R1 done high, irq low", {rx_end, tx_end, irq}, 3'b110);
    chk(!spi_rd && !spi_wr && !mem_req, "R1 no strobes", {spi_rd, spi_wr, mem_req}, 0);

    // R9 interrupt combination
    cfg_write(3'd4, 16'h0000);
    chk(irq == 0, "R9 irq masked", irq, 0);
    cfg_write(3'd4, 16'h0001);
    chk(irq == 1, "R9 irq inbound only", irq, 1);
    cfg_write(3'd4, 16'h0002);
    chk(irq == 1, "R9 irq outbound only", irq, 1);
    cfg_write(3'd1, 16'd5);
    chk(rx_end == 0, "R8 nonzero count clears done", rx_end, 0);
    cfg_write(3'd4, 16'h0001);
    chk(irq == 0, "R9 inbound busy masks irq", irq, 0);
    cfg_write(3'd4, 16'h0003);
    chk(irq == 1, "R9 outbound done drives irq", irq, 1);
    cfg_write(3'd1, 16'd0);
    chk(rx_end == 1, "R5 zero count sets done", rx_end, 1);

    // R8 pointer write keeps done
    cfg_write(3'd0, 16'h0033);
    chk(rx_end == 1 && rx_ptr == 16'h0033, "R8 pointer write keeps done", {rx_end, rx_ptr}, {1'b1, 16'h0033});
    cfg_write(3'd2, 16'h0055);
    chk(tx_end == 1 && tx_ptr == 16'h0055, "R8 outbound pointer write keeps done", {tx_end, tx_ptr}, {1'b1, 16'h0055});

    // sweep: size x count x grant latency
    for (int hw = 0; hw < 2; hw++)
      for (int n = 1; n <= 4; n++)
        for (int l = 0; l < 3; l++) begin
          run_rx(n, hw, l);
          run_tx(n, hw, l);
        end

    // R6: raised flags with zero counts
    begin
      int r0, w0, m0;
      lat = 0;
      r0 = rd_total; w0 = wr_total; m0 = mreq_total;
      rx_target = rx_target + 1;
      tx_target = tx_target + 1;
      repeat (20) @(negedge clk);
      chk(spi_rx_full && rd_total == r0, "R6 inbound blocked at zero", rd_total - r0, 0);
      chk(spi_tx_empty && wr_total == w0, "R6 outbound blocked at zero", wr_total - w0, 0);
      chk(mreq_total == m0, "R6 no memory request at zero", mreq_total - m0, 0);
    end

    // R2/R5/R8 cycle-exact inbound word, byte mode, flag already pending
    begin
      int k0;
      k0 = rx_sent;
      cfg_write(3'd4, 16'h0000);
      cfg_write(3'd0, 16'h0010);
      cfg_write(3'd1, 16'd1);
      chk(rx_end == 0 && !spi_rd, "R8 done low one cycle after count write", rx_end, 0);
      @(negedge clk);
      chk(spi_rd && !mem_req, "R2 read strobe one cycle after start", {spi_rd, mem_req}, 2'b10);
      @(negedge clk);
      chk(!spi_rd && mem_req && mem_we && mem_addr == 16'h0010, "R2 memory write request", {spi_rd, mem_req, mem_we}, 3'b011);
      @(negedge clk);
      chk(rx_end && rx_cnt == 0 && rx_ptr == 16'h0011, "R5 done right after final grant", {rx_end, rx_ptr}, {1'b1, 16'h0011});
      chk(wmem[8'h10] == {8'h00, rxpat(k0)[7:0]}, "R2 byte mode zero upper byte", wmem[8'h10], {8'h00, rxpat(k0)[7:0]});
    end

    // R7: flag held high yields one transfer
    begin
      int r0;
      r0 = rd_total;
      rx_hold = 1;
      lat = 0;
      cfg_write(3'd0, 16'h0020);
      rx_target = rx_target + 3;
      cfg_write(3'd1, 16'd3);
      repeat (30) @(negedge clk);
      chk(rd_total == r0 + 1 && rx_cnt == 2, "R7 one transfer per flag", rd_total - r0, 1);
      rx_hold = 0;
      wait_rx_done();
      chk(rd_total == r0 + 3 && rx_cnt == 0, "R7 resumes after flag drop", rd_total - r0, 3);
    end

    // R10: both channels at once through the shared port
    begin
      int k0, g0, w0;
      bit ok;
      lat = 1;
      cfg_write(3'd4, 16'h0004);
      cfg_write(3'd0, 16'h0040);
      cfg_write(3'd2, 16'h0080);
      k0 = rx_sent; g0 = tx_got; w0 = wr_total;
      rx_target = rx_target + 3;
      tx_target = tx_target + 2;
      cfg_write(3'd1, 16'd3);
      cfg_write(3'd3, 16'd3);
      wait_rx_done();
      wait_tx_done(w0 + 3);
      ok = 1;
      for (int k = 0; k < 3; k++) begin
        if (wmem[8'(16'h0040 + 16'(2 * k))] !== rxpat(k0 + k)) ok = 0;
        if (tx_log[8'(g0 + k)] !== txpat(16'h0080 + 16'(2 * k))) ok = 0;
      end
      chk(ok && wr_total == w0 + 3, "R10 concurrent channels data", wr_total - w0, 3);
      chk(rx_ptr == 16'h0046 && tx_ptr == 16'h0086, "R10 concurrent addresses", rx_ptr, 16'h0046);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule